// File: doc/BRIEF.md
# Prescaler and Square-Wave Output

This block turns a 32.768 kHz oscillator enable pulse into the once-per-second tick that advances the calendar. It also drives a square-wave pin whose rate software picks through an 8-bit control register. A 15-bit counter counts oscillator pulses. Three of its bits serve as the 1 Hz, 4.096 kHz and 8.192 kHz taps. The fastest rate repeats the oscillator pulse itself on the pin.

Writing the seconds register restarts the counter from zero. The 1 Hz wave therefore rises exactly half a second after that write, and the calendar tick follows one full second after it. While the clock-halt input is set, the counter holds its value. When the square wave is disabled, the pin carries a static level taken from the control register.

Top module: `sqw_prescaler`

## Requirements
- R1: After reset the control register reads 0x00. A write stores bit 7 (static level), bit 4 (wave enable) and bits 1:0 (rate code). Bits 6, 5, 3 and 2 always read 0. The new value is visible on the read port in the cycle after the write strobe is sampled.
- R2: With bit 4 clear, `sqw_out` equals bit 7 of the control register, one cycle after that register changes.
- R3: A seconds write (`sec_wr`) clears the 15-bit counter. With rate code 00 and the wave enabled, `sqw_out` is low after the 16383rd counted pulse and high after the 16384th, one cycle after that pulse is sampled.
- R4: While `clk_halt` is high, oscillator pulses are not counted, so neither `sqw_out` nor `sec_tick` changes.
- R5: Rate code 01 makes the pin high while counter bit 2 is set, so it is high for pulse counts 4 to 7 modulo 8. Code 10 uses bit 1, so the pin is high for counts 2 and 3 modulo 4. Code 11 makes the pin high for one cycle, in the cycle after each counted pulse.
- R6: `sec_tick` is a one-cycle pulse. It comes one cycle after the 32768th counted pulse following a seconds write, when the 1 Hz wave falls.
- R7: A seconds write sampled in the same cycle as the wrapping pulse takes priority, and no `sec_tick` is produced.
- R8: A seconds write while halted still clears the counter. Counting resumes from zero when the halt is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable per 32.768 kHz oscillator period |
| clk_halt | input | 1 | Clock-halt bit; freezes the counter |
| sec_wr | input | 1 | Strobe for a write to the seconds register |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read value |
| sqw_out | output | 1 | Square-wave / static level pin |
| sec_tick | output | 1 | 1 Hz pulse to the calendar |

## Verification
The bench aims at the exact pulse on which the 1 Hz wave rises after a seconds write. A design that left the counter running, or that counted one pulse too many or too few, would move that rise by a cycle or by half a second. It halts the clock for longer than half a period, so a halt that still counted would flip the pin. It also lands a seconds write on the wrapping pulse, where a wrong priority would emit a stray calendar tick. The reserved control bits and the fast taps are checked pulse by pulse, which exposes a tap taken from the wrong counter bit.

// File: rtl/sqw_prescaler_pkg.sv
package sqw_prescaler_pkg;

    // rate codes carried in control bits 1:0
    typedef enum logic [1:0] {
        RATE_1HZ  = 2'b00,
        RATE_4K   = 2'b01,
        RATE_8K   = 2'b10,
        RATE_OSC  = 2'b11
    } rate_sel_e;

    localparam int unsigned CTRL_W       = 8;
    localparam int unsigned CTRL_LVL_BIT = 7;
    localparam int unsigned CTRL_EN_BIT  = 4;
    localparam logic [CTRL_W-1:0] CTRL_MASK  = 8'h93;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h00;

    typedef struct packed {
        logic      lvl;
        logic      wave_en;
        rate_sel_e rate;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] raw);
        ctrl_t c;
        c.lvl     = raw[CTRL_LVL_BIT];
        c.wave_en = raw[CTRL_EN_BIT];
        c.rate    = rate_sel_e'(raw[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/sqw_divider.sv
module sqw_divider #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             halt,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt_q,
    output logic             adv_q,
    output logic             wrap_q
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             adv;
        logic             wrap;
    } div_s;

    localparam div_s DIV_RESET = '{cnt: '0, adv: 1'b0, wrap: 1'b0};

    div_s st_d, st_q;
    logic count_en;

    always_comb begin
        st_d      = st_q;
        st_d.adv  = 1'b0;
        st_d.wrap = 1'b0;
        count_en  = osc_tick & ~halt;
        if (restart) begin
            st_d.cnt = '0;
        end else if (count_en) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.adv  = 1'b1;
            st_d.wrap = &st_q.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= DIV_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q  = st_q.cnt;
    assign adv_q  = st_q.adv;
    assign wrap_q = st_q.wrap;

endmodule

// File: rtl/sqw_ctrl_reg.sv
module sqw_ctrl_reg
    import sqw_prescaler_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output ctrl_t             ctrl
);

    typedef struct packed {
        logic [CTRL_W-1:0] raw;
    } reg_s;

    reg_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.raw = wdata & CTRL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.raw <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.raw;
    assign ctrl  = decode_ctrl(st_q.raw);

endmodule

// File: rtl/sqw_wave_out.sv
module sqw_wave_out
    import sqw_prescaler_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  logic  tap_1hz,
    input  logic  tap_4k,
    input  logic  tap_8k,
    input  logic  adv,
    input  logic  wrap,
    output logic  pin_q,
    output logic  tick_q
);

    typedef struct packed {
        logic pin;
        logic tick;
    } out_s;

    out_s st_d, st_q;
    logic wave;

    always_comb begin
        unique case (ctrl.rate)
            RATE_1HZ: wave = tap_1hz;
            RATE_4K:  wave = tap_4k;
            RATE_8K:  wave = tap_8k;
            default:  wave = adv;
        endcase
        st_d      = st_q;
        st_d.pin  = ctrl.wave_en ? wave : ctrl.lvl;
        st_d.tick = wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_q  = st_q.pin;
    assign tick_q = st_q.tick;

endmodule

// File: rtl/sqw_prescaler.sv
module sqw_prescaler
    import sqw_prescaler_pkg::*;
#(
    parameter int unsigned CNT_W   = 15,
    parameter int unsigned TAP_4K  = 2,
    parameter int unsigned TAP_8K  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       clk_halt,
    input  logic       sec_wr,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_wdata,
    output logic [7:0] ctrl_rdata,
    output logic       sqw_out,
    output logic       sec_tick
);

    localparam int unsigned TAP_1HZ = CNT_W - 1;

    logic [CNT_W-1:0] div_cnt;
    logic             div_adv;
    logic             div_wrap;
    ctrl_t            ctrl;

    sqw_divider #(.CNT_W(CNT_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .halt     (clk_halt),
        .restart  (sec_wr),
        .cnt_q    (div_cnt),
        .adv_q    (div_adv),
        .wrap_q   (div_wrap)
    );

    sqw_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctrl_wr),
        .wdata (ctrl_wdata),
        .rdata (ctrl_rdata),
        .ctrl  (ctrl)
    );

    sqw_wave_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl),
        .tap_1hz (div_cnt[TAP_1HZ]),
        .tap_4k  (div_cnt[TAP_4K]),
        .tap_8k  (div_cnt[TAP_8K]),
        .adv     (div_adv),
        .wrap    (div_wrap),
        .pin_q   (sqw_out),
        .tick_q  (sec_tick)
    );

endmodule

// File: rtl/sqw_prescaler_chk.sv
module sqw_prescaler_chk #(
    parameter int unsigned CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_halt,
    input logic             sec_wr,
    input logic             ctrl_wr,
    input logic [7:0]       ctrl_wdata,
    input logic [7:0]       ctrl_rdata,
    input logic             sqw_out,
    input logic             sec_tick,
    input logic [CNT_W-1:0] cnt
);

    AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ctrl_rdata == ($past(ctrl_wdata) & 8'h93)); // R1

    AST_STATIC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[4] |=> sqw_out == $past(ctrl_rdata[7])); // R2

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr |=> cnt == '0); // R3

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_halt && !sec_wr) |=> $stable(cnt)); // R4

    AST_TICK_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> ($past(cnt, 2) == '1 && $past(cnt) == '0)); // R6

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick); // R6

    AST_RESTART_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr |=> ##1 !sec_tick); // R7

endmodule

bind sqw_prescaler sqw_prescaler_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_halt   (clk_halt),
    .sec_wr     (sec_wr),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_rdata (ctrl_rdata),
    .sqw_out    (sqw_out),
    .sec_tick   (sec_tick),
    .cnt        (div_cnt)
);

// File: tb/sqw_prescaler_tb.sv
module sqw_prescaler_tb;

    localparam int SIG_PIN  = 0;
    localparam int SIG_TICK = 1;
    localparam int SIG_CTRL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       clk_halt = 1'b0;
    logic       sec_wr = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] ctrl_rdata;
    logic       sqw_out;
    logic       sec_tick;

    int unsigned cyc = 0;
    int n_cmp = 0;
    int n_err = 0;
    bit done = 1'b0;

    typedef struct {
        int unsigned cyc;
        int          sig;
        logic [7:0]  val;
        string       req;
    } exp_t;

    exp_t       sb_q[$];
    exp_t       mon_e;
    logic [7:0] mon_act;

    sqw_prescaler u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_tick   (osc_tick),
        .clk_halt   (clk_halt),
        .sec_wr     (sec_wr),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .sqw_out    (sqw_out),
        .sec_tick   (sec_tick)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected items whose cycle has come
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
            mon_e = sb_q.pop_front();
            case (mon_e.sig)
                SIG_PIN:  mon_act = {7'd0, sqw_out};
                SIG_TICK: mon_act = {7'd0, sec_tick};
                default:  mon_act = ctrl_rdata;
            endcase
            n_cmp++;
            if (mon_e.cyc != cyc || mon_act !== mon_e.val) begin
                n_err++;
                $display("FAIL %s sig=%0d cyc=%0d actual=%h expected=%h",
                         mon_e.req, mon_e.sig, cyc, mon_act, mon_e.val);
            end
        end
    end

    task automatic expect_at(input int d, input int sig, input logic [7:0] v, input string r);
        exp_t e;
        e.cyc = cyc + d;
        e.sig = sig;
        e.val = v;
        e.req = r;
        sb_q.push_back(e);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        ctrl_wdata = v;
        ctrl_wr    = 1'b1;
        @(negedge clk);
        ctrl_wr    = 1'b0;
    endtask

    task automatic restart_sec();
        sec_wr = 1'b1;
        @(negedge clk);
        sec_wr = 1'b0;
    endtask

    task automatic one_tick();
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        if (n > 0) begin
            osc_tick = 1'b1;
            repeat (n) @(negedge clk);
            osc_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_at(1, SIG_CTRL, 8'h00, "R1");
        expect_at(1, SIG_PIN, 8'h00, "R1");
        expect_at(1, SIG_TICK, 8'h00, "R1");
        idle(2);

        // R1 reserved bits read zero; R2 static level
        write_ctrl(8'h6C);
        expect_at(1, SIG_CTRL, 8'h00, "R1");
        expect_at(1, SIG_PIN, 8'h00, "R2");
        idle(2);
        write_ctrl(8'h80);
        expect_at(1, SIG_CTRL, 8'h80, "R1");
        expect_at(1, SIG_PIN, 8'h01, "R2");
        idle(2);
        write_ctrl(8'h00);
        expect_at(1, SIG_PIN, 8'h00, "R2");
        idle(2);

        // R5 code 11: pin follows each counted pulse
        write_ctrl(8'hFF);
        expect_at(1, SIG_CTRL, 8'h93, "R1");
        expect_at(1, SIG_PIN, 8'h00, "R5");
        idle(2);
        for (int i = 0; i < 3; i++) begin
            one_tick();
            expect_at(1, SIG_PIN, 8'h01, "R5");
            expect_at(2, SIG_PIN, 8'h00, "R5");
            idle(2);
        end

        // R5 code 01: high for counts 4..7 mod 8
        write_ctrl(8'h11);
        restart_sec();
        expect_at(1, SIG_PIN, 8'h00, "R3");
        idle(1);
        for (int n = 1; n <= 9; n++) begin
            one_tick();
            expect_at(1, SIG_PIN, {7'd0, ((n % 8) >= 4)}, "R5");
            idle(1);
        end

        // R5 code 10: high for counts 2..3 mod 4
        write_ctrl(8'h12);
        restart_sec();
        idle(1);
        for (int n = 1; n <= 6; n++) begin
            one_tick();
            expect_at(1, SIG_PIN, {7'd0, ((n % 4) >= 2)}, "R5");
            idle(1);
        end

        // R3 / R6 1 Hz phase after a seconds write
        write_ctrl(8'h10);
        restart_sec();
        expect_at(1, SIG_PIN, 8'h00, "R3");
        run_ticks(16383);
        expect_at(1, SIG_PIN, 8'h00, "R3");
        one_tick();
        expect_at(1, SIG_PIN, 8'h01, "R3");
        run_ticks(16383);
        expect_at(1, SIG_PIN, 8'h01, "R6");
        expect_at(1, SIG_TICK, 8'h00, "R6");
        one_tick();
        expect_at(1, SIG_TICK, 8'h01, "R6");
        expect_at(1, SIG_PIN, 8'h00, "R6");
        expect_at(2, SIG_TICK, 8'h00, "R6");
        idle(3);

        // R8 seconds write while halted; R4 no counting while halted
        clk_halt = 1'b1;
        restart_sec();
        run_ticks(16384);
        expect_at(1, SIG_PIN, 8'h00, "R4");
        expect_at(1, SIG_TICK, 8'h00, "R4");
        clk_halt = 1'b0;
        run_ticks(16383);
        expect_at(1, SIG_PIN, 8'h00, "R8");
        one_tick();
        expect_at(1, SIG_PIN, 8'h01, "R8");
        idle(1);

        // R4 frozen with the pin high
        clk_halt = 1'b1;
        run_ticks(16384);
        expect_at(1, SIG_PIN, 8'h01, "R4");
        expect_at(1, SIG_TICK, 8'h00, "R4");
        idle(2);
        clk_halt = 1'b0;
        idle(1);

        // R7 seconds write coincident with the wrapping pulse
        restart_sec();
        run_ticks(32767);
        expect_at(1, SIG_PIN, 8'h01, "R7");
        sec_wr   = 1'b1;
        osc_tick = 1'b1;
        @(negedge clk);
        sec_wr   = 1'b0;
        osc_tick = 1'b0;
        expect_at(1, SIG_TICK, 8'h00, "R7");
        expect_at(1, SIG_PIN, 8'h00, "R7");
        expect_at(2, SIG_TICK, 8'h00, "R7");
        idle(2);
        run_ticks(16383);
        expect_at(1, SIG_PIN, 8'h00, "R7");
        one_tick();
        expect_at(1, SIG_PIN, 8'h01, "R7");

        idle(4);
        if (sb_q.size() != 0) begin
            n_err++;
            $display("FAIL scoreboard actual=%0d pending expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule